// File: doc/BRIEF.md
# Boundary-Scan Register for a Dual 9-Bit Transceiver

This block is the boundary register of a test access port for a transceiver built from two 9-bit groups. It contains a 52-cell serial chain and a parallel shadow stage behind it. Each data pin has a single cell that serves both as the input sample and as the output value. Each of the twelve control inputs has its own cell, and four more cells hold the decoded drive enables of the A and B ports for each group.

The TAP controller supplies three strobes. Capture loads the chain in parallel, shift moves it one place from TDI toward TDO, and update copies the chain into the shadow stage. A capture either samples the pins, or, when the core source is selected, samples the core's own output values and enables. With the test-mode input high, the port outputs, the port enables and the control values passed to the core all come from the shadow stage. With it low, the core and the control pins drive straight through. The four enable cells clear on reset, so a later entry into test mode starts with every port output in high impedance.

Top module: `bsr_boundary_reg`

## Requirements
- R1: The chain is 52 cells long. A bit presented on `tdi_i` during a shift cycle reaches `tdo_o` after 52 shift cycles. `tdo_o` always shows cell 0, and during a shift every cell takes the value of the cell above it, with cell 51 taking `tdi_i`.
- R2: While `rst_ni` is low, cells 48 to 51 of both the chain and the shadow stage are 0. In test mode this makes `a_oe_o` and `b_oe_o` all 0 (outputs undriven). The other cells are not reset.
- R3: Cells 36 to 47 hold the control inputs, with `ctrl_pin_i[i]` going to cell 36+i. The index pairs are SBA (0,1), SAB (2,3), CLKBA (4,5), CLKAB (6,7), OE (8,9) and DIR (10,11), and the lower index of each pair belongs to group 1. Control cells capture the pins for either capture source.
- R4: Cells 18 to 35 are the A pins and cells 0 to 17 are the B pins. In both ranges, bit j of the port vector maps to cell base+j, with group 1 in bits 0 to 8 and group 2 in bits 9 to 17.
- R5: A pin capture (`cap_core_i`=0) loads each data cell from its pin. It also loads each enable cell with a decoded value. Cell 48+g (A enable of group g+1) becomes 1 when OE and DIR of that group are both 0. Cell 50+g (B enable) becomes 1 when OE is 0 and DIR is 1.
- R6: A core capture (`cap_core_i`=1) loads the data cells from `a_core_i` and `b_core_i`. It loads cells 48+g from `a_core_en_i[g]` and cells 50+g from `b_core_en_i[g]`.
- R7: A cycle with `update_i` high copies the chain into the shadow stage. In test mode the outputs then take these values: `a_out_o` and `b_out_o` from the A and B cells, `a_oe_o[g]` from cell 48+g, `b_oe_o[g]` from cell 50+g, and `ctrl_core_o` from cells 36 to 47.
- R8: In test mode, capture and shift cycles leave every output unchanged until the next update.
- R9: With `test_mode_i` low, the outputs follow `a_core_i`, `b_core_i`, `a_core_en_i`, `b_core_en_i` and `ctrl_pin_i`, whatever the shadow stage holds.
- R10: In a cycle with neither capture nor shift, the chain holds its contents, whatever value `tdi_i` has.
- R11: When capture and shift are high in the same cycle, the capture takes effect and no shift happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset (test-logic reset) |
| capture_i | input | 1 | Parallel load of the chain |
| shift_i | input | 1 | Shift the chain one cell toward TDO |
| update_i | input | 1 | Copy the chain into the shadow stage |
| test_mode_i | input | 1 | Drive outputs from the shadow stage |
| cap_core_i | input | 1 | Capture source: 0 pins, 1 core |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (cell 0) |
| ctrl_pin_i | input | 12 | Control input levels |
| ctrl_core_o | output | 12 | Control values presented to the core |
| a_pin_i | input | 18 | A port pin levels |
| b_pin_i | input | 18 | B port pin levels |
| a_core_i | input | 18 | Core value for the A outputs |
| b_core_i | input | 18 | Core value for the B outputs |
| a_core_en_i | input | 2 | Core drive enable of the A port, per group |
| b_core_en_i | input | 2 | Core drive enable of the B port, per group |
| a_out_o | output | 18 | Value driven on the A port |
| b_out_o | output | 18 | Value driven on the B port |
| a_oe_o | output | 2 | A port drive enable, per group |
| b_oe_o | output | 2 | B port drive enable, per group |

## Verification
Shifting and output driving can happen in the same cycle. A full capture and 52-cycle scan runs while test mode holds the outputs on a loaded shadow, and every output is compared with the previously updated pattern on each shift cycle. Capture and shift can also coincide. The bench raises both strobes in one cycle and then scans the chain out; the result must be the captured pattern with no shift applied on top.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // control field order inside the control cell range, one entry per group
  typedef enum int unsigned {
    FLD_SBA   = 0,
    FLD_SAB   = 1,
    FLD_CLKBA = 2,
    FLD_CLKAB = 3,
    FLD_OE    = 4,
    FLD_DIR   = 5
  } ctrl_fld_e;

  localparam int unsigned NUM_FLD = 6;

  function automatic int unsigned ctrl_ix(int unsigned fld, int unsigned grp,
                                          int unsigned groups);
    return fld * groups + grp;
  endfunction
endpackage

// File: rtl/bsr_split_reg.sv
module bsr_split_reg #(
  parameter int unsigned W      = 52,
  parameter int unsigned RST_LO = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // bits [W-1:RST_LO] clear on reset; lower bits carry no reset
  logic [W-1:RST_LO] safe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   safe_q <= '0;
    else if (en_i) safe_q <= d_i[W-1:RST_LO];
  end

  generate
    if (RST_LO > 0) begin : g_free
      logic [RST_LO-1:0] free_q;
      always_ff @(posedge clk_i) begin
        if (en_i) free_q <= d_i[RST_LO-1:0];
      end
      assign q_o = {safe_q, free_q};
    end else begin : g_all_safe
      assign q_o = safe_q;
    end
  endgenerate
endmodule

// File: rtl/bsr_capture_sel.sv
module bsr_capture_sel import bsr_pkg::*; #(
  parameter  int unsigned GROUPS = 2,
  parameter  int unsigned CH_W   = 9,
  localparam int unsigned NIO    = GROUPS * CH_W,
  localparam int unsigned NC     = NUM_FLD * GROUPS,
  localparam int unsigned EN_LO  = 2 * NIO + NC,
  localparam int unsigned LEN    = EN_LO + 2 * GROUPS
) (
  input  logic              cap_core_i,
  input  logic [NC-1:0]     ctrl_pin_i,
  input  logic [NIO-1:0]    a_pin_i,
  input  logic [NIO-1:0]    b_pin_i,
  input  logic [NIO-1:0]    a_core_i,
  input  logic [NIO-1:0]    b_core_i,
  input  logic [GROUPS-1:0] a_core_en_i,
  input  logic [GROUPS-1:0] b_core_en_i,
  output logic [LEN-1:0]    cap_o
);
  logic [GROUPS-1:0] a_en_dec, b_en_dec;

  for (genvar g = 0; g < GROUPS; g++) begin : g_dec
    localparam int unsigned OE_IX  = ctrl_ix(FLD_OE, g, GROUPS);
    localparam int unsigned DIR_IX = ctrl_ix(FLD_DIR, g, GROUPS);
    assign a_en_dec[g] = ~ctrl_pin_i[OE_IX] & ~ctrl_pin_i[DIR_IX];
    assign b_en_dec[g] = ~ctrl_pin_i[OE_IX] &  ctrl_pin_i[DIR_IX];
  end

  always_comb begin
    cap_o[0 +: NIO]      = cap_core_i ? b_core_i : b_pin_i;
    cap_o[NIO +: NIO]    = cap_core_i ? a_core_i : a_pin_i;
    cap_o[2*NIO +: NC]   = ctrl_pin_i;
    cap_o[EN_LO +: GROUPS]          = cap_core_i ? a_core_en_i : a_en_dec;
    cap_o[EN_LO+GROUPS +: GROUPS]   = cap_core_i ? b_core_en_i : b_en_dec;
  end
endmodule

// File: rtl/bsr_drive_mux.sv
module bsr_drive_mux import bsr_pkg::*; #(
  parameter  int unsigned GROUPS = 2,
  parameter  int unsigned CH_W   = 9,
  localparam int unsigned NIO    = GROUPS * CH_W,
  localparam int unsigned NC     = NUM_FLD * GROUPS,
  localparam int unsigned EN_LO  = 2 * NIO + NC,
  localparam int unsigned LEN    = EN_LO + 2 * GROUPS
) (
  input  logic              test_mode_i,
  input  logic [LEN-1:0]    sh_i,
  input  logic [NC-1:0]     ctrl_pin_i,
  input  logic [NIO-1:0]    a_core_i,
  input  logic [NIO-1:0]    b_core_i,
  input  logic [GROUPS-1:0] a_core_en_i,
  input  logic [GROUPS-1:0] b_core_en_i,
  output logic [NC-1:0]     ctrl_core_o,
  output logic [NIO-1:0]    a_out_o,
  output logic [NIO-1:0]    b_out_o,
  output logic [GROUPS-1:0] a_oe_o,
  output logic [GROUPS-1:0] b_oe_o
);
  always_comb begin
    if (test_mode_i) begin
      b_out_o     = sh_i[0 +: NIO];
      a_out_o     = sh_i[NIO +: NIO];
      ctrl_core_o = sh_i[2*NIO +: NC];
      a_oe_o      = sh_i[EN_LO +: GROUPS];
      b_oe_o      = sh_i[EN_LO+GROUPS +: GROUPS];
    end else begin
      b_out_o     = b_core_i;
      a_out_o     = a_core_i;
      ctrl_core_o = ctrl_pin_i;
      a_oe_o      = a_core_en_i;
      b_oe_o      = b_core_en_i;
    end
  end
endmodule

// File: rtl/bsr_boundary_reg.sv
module bsr_boundary_reg import bsr_pkg::*; #(
  parameter  int unsigned GROUPS = 2,
  parameter  int unsigned CH_W   = 9,
  localparam int unsigned NIO    = GROUPS * CH_W,
  localparam int unsigned NC     = NUM_FLD * GROUPS,
  localparam int unsigned EN_LO  = 2 * NIO + NC,
  localparam int unsigned LEN    = EN_LO + 2 * GROUPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              test_mode_i,
  input  logic              cap_core_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic [NC-1:0]     ctrl_pin_i,
  output logic [NC-1:0]     ctrl_core_o,
  input  logic [NIO-1:0]    a_pin_i,
  input  logic [NIO-1:0]    b_pin_i,
  input  logic [NIO-1:0]    a_core_i,
  input  logic [NIO-1:0]    b_core_i,
  input  logic [GROUPS-1:0] a_core_en_i,
  input  logic [GROUPS-1:0] b_core_en_i,
  output logic [NIO-1:0]    a_out_o,
  output logic [NIO-1:0]    b_out_o,
  output logic [GROUPS-1:0] a_oe_o,
  output logic [GROUPS-1:0] b_oe_o
);
  logic [LEN-1:0] cap_vec, chain_q, chain_d, shadow_q;
  logic           chain_en;

  bsr_capture_sel #(.GROUPS(GROUPS), .CH_W(CH_W)) u_cap (
    .cap_core_i  (cap_core_i),
    .ctrl_pin_i  (ctrl_pin_i),
    .a_pin_i     (a_pin_i),
    .b_pin_i     (b_pin_i),
    .a_core_i    (a_core_i),
    .b_core_i    (b_core_i),
    .a_core_en_i (a_core_en_i),
    .b_core_en_i (b_core_en_i),
    .cap_o       (cap_vec)
  );

  // capture has priority over shift
  always_comb begin
    chain_en = capture_i | shift_i;
    chain_d  = capture_i ? cap_vec : {tdi_i, chain_q[LEN-1:1]};
  end

  bsr_split_reg #(.W(LEN), .RST_LO(EN_LO)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (chain_en),
    .d_i    (chain_d),
    .q_o    (chain_q)
  );

  bsr_split_reg #(.W(LEN), .RST_LO(EN_LO)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (update_i),
    .d_i    (chain_q),
    .q_o    (shadow_q)
  );

  bsr_drive_mux #(.GROUPS(GROUPS), .CH_W(CH_W)) u_drv (
    .test_mode_i (test_mode_i),
    .sh_i        (shadow_q),
    .ctrl_pin_i  (ctrl_pin_i),
    .a_core_i    (a_core_i),
    .b_core_i    (b_core_i),
    .a_core_en_i (a_core_en_i),
    .b_core_en_i (b_core_en_i),
    .ctrl_core_o (ctrl_core_o),
    .a_out_o     (a_out_o),
    .b_out_o     (b_out_o),
    .a_oe_o      (a_oe_o),
    .b_oe_o      (b_oe_o)
  );

  assign tdo_o = chain_q[0];

  // R2: enables held safe during reset
  always @(posedge clk_i) begin
    if (!rst_ni && test_mode_i)
      a_r2_safe_enables: assert (a_oe_o == '0 && b_oe_o == '0);
  end

  a_r5_pin_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i && !cap_core_i |=> tdo_o == $past(b_pin_i[0]));

  a_r6_core_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i && cap_core_i |=> tdo_o == $past(b_core_i[0]));

  a_r8_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && !update_i |=> !test_mode_i ||
      ($stable(a_out_o) && $stable(b_out_o) && $stable(a_oe_o) &&
       $stable(b_oe_o) && $stable(ctrl_core_o)));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i && !shift_i |=> $stable(tdo_o));
endmodule

// File: tb/bsr_boundary_reg_test.sv
module bsr_boundary_reg_test;
  localparam int LEN = 52;

  logic        clk_i = 1'b0;
  logic        rst_ni, capture_i, shift_i, update_i, test_mode_i, cap_core_i, tdi_i;
  logic        tdo_o;
  logic [11:0] ctrl_pin_i, ctrl_core_o;
  logic [17:0] a_pin_i, b_pin_i, a_core_i, b_core_i, a_out_o, b_out_o;
  logic [1:0]  a_core_en_i, b_core_en_i, a_oe_o, b_oe_o;

  int n_chk = 0;
  int n_err = 0;

  logic  exp_q[$];
  string tag_q[$];
  logic        hold_chk = 1'b0;
  logic [LEN-1:0] hold_exp;

  always #2 clk_i = ~clk_i;

  bsr_boundary_reg uut (
    .clk_i, .rst_ni, .capture_i, .shift_i, .update_i, .test_mode_i, .cap_core_i,
    .tdi_i, .tdo_o, .ctrl_pin_i, .ctrl_core_o, .a_pin_i, .b_pin_i, .a_core_i,
    .b_core_i, .a_core_en_i, .b_core_en_i, .a_out_o, .b_out_o, .a_oe_o, .b_oe_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] exp_pin(logic [11:0] c, logic [17:0] a, logic [17:0] b);
    logic [LEN-1:0] v;
    v[17:0]  = b;
    v[35:18] = a;
    v[47:36] = c;
    v[48] = ~c[8] & ~c[10];
    v[49] = ~c[9] & ~c[11];
    v[50] = ~c[8] &  c[10];
    v[51] = ~c[9] &  c[11];
    return v;
  endfunction

  function automatic logic [LEN-1:0] exp_core(logic [11:0] c, logic [17:0] a,
      logic [17:0] b, logic [1:0] ae, logic [1:0] be);
    return {be, ae, c, a, b};
  endfunction

  function automatic logic [LEN-1:0] out_vec();
    return {b_oe_o, a_oe_o, ctrl_core_o, a_out_o, b_out_o};
  endfunction

  // monitor: pops one expected TDO bit per shift cycle
  always @(negedge clk_i) begin
    logic  e;
    string t;
    #1;
    if (rst_ni && shift_i && !capture_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected shift", 64'(tdo_o), 64'hx);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(tdo_o === e, t, 64'(tdo_o), 64'(e));
      end
    end
    if (hold_chk)
      chk(out_vec() === hold_exp, "R8 outputs moved during scan", 64'(out_vec()), 64'(hold_exp));
  end

  task automatic shift_vec(input logic [LEN-1:0] din, input logic [LEN-1:0] exp, input string tag);
    for (int i = 0; i < LEN; i++) begin
      exp_q.push_back(exp[i]);
      tag_q.push_back(tag);
      tdi_i   = din[i];
      shift_i = 1'b1;
      @(negedge clk_i);
    end
    shift_i = 1'b0;
  endtask

  task automatic capture_scan(input bit core, input logic [LEN-1:0] din,
                              input logic [LEN-1:0] exp, input string tag);
    @(negedge clk_i);
    cap_core_i = core;
    capture_i  = 1'b1;
    @(negedge clk_i);
    capture_i  = 1'b0;
    shift_vec(din, exp, tag);
  endtask

  task automatic do_update();
    @(negedge clk_i);
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
    #1;
  endtask

  initial begin
    logic [LEN-1:0] d1, d2, e;
    rst_ni = 1'b1; capture_i = 0; shift_i = 0; update_i = 0; test_mode_i = 0;
    cap_core_i = 0; tdi_i = 0;
    ctrl_pin_i = 12'h5a3; a_pin_i = 18'h2b4c1; b_pin_i = 18'h1d0e7;
    a_core_i = 18'h3c3c3; b_core_i = 18'h0f0f1; a_core_en_i = 2'b10; b_core_en_i = 2'b01;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    test_mode_i = 1'b1;
    #1;
    // R2 reset state of enables
    chk(a_oe_o === 2'b00 && b_oe_o === 2'b00, "R2 enables after reset",
        64'({b_oe_o, a_oe_o}), 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 R4 R5: pin capture, default pattern
    d1 = 52'h9_8765_4321_ABCD;
    capture_scan(1'b0, d1, exp_pin(ctrl_pin_i, a_pin_i, b_pin_i), "R5 pin capture map R3 R4");
    do_update();
    chk(out_vec() === d1, "R7 outputs from shadow", 64'(out_vec()), 64'(d1));

    // R8: capture and scan while test mode drives the loaded shadow
    hold_exp = d1;
    hold_chk = 1'b1;
    a_pin_i = 18'h15555; b_pin_i = 18'h2aaaa; ctrl_pin_i = 12'h3c6;
    d2 = 52'h6_1357_9BDF_0246;
    capture_scan(1'b0, d2, exp_pin(ctrl_pin_i, a_pin_i, b_pin_i), "R5 pin capture under test mode");
    @(negedge clk_i);
    hold_chk = 1'b0;
    do_update();
    chk(out_vec() === d2, "R7 second update", 64'(out_vec()), 64'(d2));

    // R9: normal mode ignores shadow
    test_mode_i = 1'b0;
    #1;
    chk(out_vec() === {b_core_en_i, a_core_en_i, ctrl_pin_i, a_core_i, b_core_i},
        "R9 normal mode pass", 64'(out_vec()),
        64'({b_core_en_i, a_core_en_i, ctrl_pin_i, a_core_i, b_core_i}));
    a_core_i = 18'h00ff1; b_core_i = 18'h3ff00; a_core_en_i = 2'b01; b_core_en_i = 2'b11;
    ctrl_pin_i = 12'h0a5;
    #1;
    chk(out_vec() === {b_core_en_i, a_core_en_i, ctrl_pin_i, a_core_i, b_core_i},
        "R9 normal mode follows core", 64'(out_vec()),
        64'({b_core_en_i, a_core_en_i, ctrl_pin_i, a_core_i, b_core_i}));

    // R5: every OE/DIR combination for both groups
    for (int c = 0; c < 16; c++) begin
      ctrl_pin_i = {4'(c), 8'(c * 37 + 11)};
      a_pin_i = 18'(c * 9103 + 5);
      b_pin_i = 18'(c * 7717 + 3);
      capture_scan(1'b0, 52'(c), exp_pin(ctrl_pin_i, a_pin_i, b_pin_i), "R5 enable decode");
    end

    // R6: core capture
    capture_scan(1'b1, d1, exp_core(ctrl_pin_i, a_core_i, b_core_i, a_core_en_i, b_core_en_i),
                 "R6 core capture");
    a_core_en_i = 2'b10; b_core_en_i = 2'b00; a_core_i = 18'h2468a; b_core_i = 18'h13579;
    capture_scan(1'b1, d2, exp_core(ctrl_pin_i, a_core_i, b_core_i, a_core_en_i, b_core_en_i),
                 "R6 core capture second");

    // R11: capture and shift in the same cycle
    @(negedge clk_i);
    cap_core_i = 1'b0; capture_i = 1'b1; shift_i = 1'b1; tdi_i = 1'b1;
    @(negedge clk_i);
    capture_i = 1'b0; shift_i = 1'b0;
    shift_vec(d1, exp_pin(ctrl_pin_i, a_pin_i, b_pin_i), "R11 capture wins over shift");

    // R10: idle cycles keep the chain
    e = exp_pin(ctrl_pin_i, a_pin_i, b_pin_i);
    @(negedge clk_i);
    capture_i = 1'b1;
    @(negedge clk_i);
    capture_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tdi_i = k[0];
      @(negedge clk_i);
    end
    shift_vec(d2, e, "R10 idle hold");

    // R1: chain length, data in reaches TDO after 52 shifts
    shift_vec(d1, d2, "R1 chain length");

    // R2: reset after enables were loaded
    shift_vec(52'hF_0000_0000_0000, d1, "R1 chain flush");
    do_update();
    test_mode_i = 1'b1;
    #1;
    chk(a_oe_o === 2'b11 && b_oe_o === 2'b11, "R7 enables loaded",
        64'({b_oe_o, a_oe_o}), 64'hf);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(a_oe_o === 2'b00 && b_oe_o === 2'b00, "R2 enables cleared by reset",
        64'({b_oe_o, a_oe_o}), 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    chk(exp_q.size() == 0, "R1 all scan bits observed", 64'(exp_q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule